// File: doc/BRIEF.md
# Energy-Based Trip and Retry Controller

This block is the digital supervisor of one channel of a protected load switch. An analog front end, outside the block, turns the overload current into a pulse train. The frequency of that pulse train grows with the square of the current above the rating. The supervisor counts these pulses. When a fixed number has accumulated, it opens the switch. Because that count stands for a fixed amount of dissipated energy, a heavy overload trips quickly and a mild overload trips slowly.

After a trip the channel waits out a cooldown interval and then closes the switch again. It tries this a limited number of times. After that it stays off until the operator commands the channel off and on again. Two further inputs act on the channel. A hysteretic over-temperature flag opens the switch for as long as it is raised. A fast secondary-fault flag trips the channel at once, without waiting for the pulse count. Each channel has its own instance and its own command input, so channels are independent.

Top module: `fuse_trip_supervisor`

## Requirements
- R1: The pulse input passes through a synchronizer of two flops and counts only on its rising edges. A level held high for many cycles counts once.
- R2: While the channel is on, the edge that brings the accumulated count to TRIP_COUNT trips it. One clock later the status is 10 and the gate enable is low.
- R3: Cooling (status 10) lasts exactly COOLDOWN_CYCLES clock cycles. The channel then returns to on (status 01) with the pulse count at zero.
- R4: At most MAX_RETRIES automatic restarts follow a rising edge of the command. A trip that happens once they are all used leads to lockout (status 11). Lockout holds for as long as the command stays high.
- R5: A rising edge of cmd_on puts the channel on, clears the restart count and clears any lockout.
- R6: While overtemp is high, gate_en is low in every state. The status is unchanged and pulses are not counted. gate_en returns when the flag clears.
- R7: fast_fault sampled high while the channel is on trips it on the next edge. The channel then follows the same cooldown and restart-limit sequence as a count trip.
- R8: While cmd_on is low, the status is 00 from the next clock on and gate_en is low. Pulses are ignored and the count is cleared. A command drop takes precedence over a cooldown that ends in the same cycle.
- R9: status encodes 00 off, 01 on, 10 cooling, 11 locked out. fault equals status[1] OR overtemp.
- R10: After reset, status is 00 and gate_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | On/off command for the channel |
| osc_pulse | input | 1 | Asynchronous overload oscillator output |
| overtemp | input | 1 | Over-temperature flag, hysteresis applied upstream |
| fast_fault | input | 1 | Fast secondary fault from the local temperature-difference limit |
| gate_en | output | 1 | Enable for the power switch gate driver |
| status | output | 2 | Channel state code (see R9) |
| fault | output | 1 | Cooling, lockout or over-temperature indication |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the final cycle of the cooldown and a drop of the command. The second pair is a fast fault and a raised over-temperature flag. The bench tracks its own reference model so that it knows when the cooldown timer sits at its last count. It releases the command in exactly that cycle and expects off rather than on. It also raises both fault flags together and expects a trip into cooldown while the gate stays low. Every clock, the status, gate and fault outputs are compared against the model.

// File: rtl/fts_pkg.sv
package fts_pkg;

   typedef enum logic [1:0] {
      CH_OFF  = 2'b00,
      CH_ON   = 2'b01,
      CH_COOL = 2'b10,
      CH_LOCK = 2'b11
   } ch_state_e;

   function automatic int safe_width(input int count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/fts_pulse_sync.sv
module fts_pulse_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_pulse
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("fts_pulse_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign rise_pulse = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

   // R1: a detected edge never repeats on the following cycle
   p_edge_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/fts_energy_accum.sv
module fts_energy_accum #(
   parameter int TRIP_COUNT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic count_en,
   output logic reach
);
   import fts_pkg::*;

   localparam int CW = safe_width(TRIP_COUNT);

   generate
      if (TRIP_COUNT < 2) begin : g_bad_trip
         $error("fts_energy_accum: TRIP_COUNT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] count;

   assign reach = count_en & ~clear & (count == CW'(TRIP_COUNT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count <= '0;
      else if (clear || reach) count <= '0;
      else if (count_en)       count <= count + 1'b1;
   end

   // R6: with no enabled edge and no clear the energy total is frozen
   p_count_paused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && !clear) |=> $stable(count));

endmodule

// File: rtl/fts_cooldown_timer.sv
module fts_cooldown_timer #(
   parameter int COOLDOWN_CYCLES = 500_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   import fts_pkg::*;

   localparam int TW = safe_width(COOLDOWN_CYCLES);

   generate
      if (COOLDOWN_CYCLES < 1) begin : g_bad_cool
         $error("fts_cooldown_timer: COOLDOWN_CYCLES must be at least 1");
      end
   endgenerate

   logic [TW-1:0] ticks;

   assign done = run & (ticks == TW'(COOLDOWN_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ticks <= '0;
      else if (!run || done) ticks <= '0;
      else                   ticks <= ticks + 1'b1;
   end

endmodule

// File: rtl/fts_retry_seq.sv
module fts_retry_seq #(
   parameter int MAX_RETRIES = 4096
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_on,
   input  logic               trip,
   input  logic               cool_done,
   output fts_pkg::ch_state_e state
);
   import fts_pkg::*;

   localparam int RW = safe_width(MAX_RETRIES + 1);

   generate
      if (MAX_RETRIES < 0) begin : g_bad_retry
         $error("fts_retry_seq: MAX_RETRIES must not be negative");
      end
   endgenerate

   logic          cmd_q;
   logic [RW-1:0] retries;
   logic          rise;
   logic          spent;

   assign rise  = cmd_on & ~cmd_q;
   assign spent = (retries == RW'(MAX_RETRIES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= CH_OFF;
         retries <= '0;
         cmd_q   <= 1'b0;
      end else begin
         cmd_q <= cmd_on;
         if (!cmd_on) begin
            state <= CH_OFF;
         end else if (rise) begin
            state   <= CH_ON;
            retries <= '0;
         end else begin
            unique case (state)
               CH_ON: begin
                  if (trip) state <= spent ? CH_LOCK : CH_COOL;
               end
               CH_COOL: begin
                  if (cool_done) begin
                     state   <= CH_ON;
                     retries <= retries + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R5: a fresh command always lands in the on state
   p_rise_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> (state == CH_ON));

   // R4: lockout persists while the command is held
   p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CH_LOCK && cmd_on) |=> (state == CH_LOCK));

   // R4: restart count never passes its limit
   p_retry_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CH_COOL) |-> (retries < RW'(MAX_RETRIES)));

endmodule

// File: rtl/fuse_trip_supervisor.sv
module fuse_trip_supervisor #(
   parameter int TRIP_COUNT      = 4096,
   parameter int COOLDOWN_CYCLES = 500_000_000,
   parameter int MAX_RETRIES     = 4096,
   parameter int SYNC_STAGES     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_on,
   input  logic       osc_pulse,
   input  logic       overtemp,
   input  logic       fast_fault,
   output logic       gate_en,
   output logic [1:0] status,
   output logic       fault
);
   import fts_pkg::*;

   ch_state_e state;
   logic      pulse_edge;
   logic      on_now;
   logic      count_en;
   logic      acc_clear;
   logic      reach;
   logic      trip;
   logic      cool_run;
   logic      cool_done;

   fts_pulse_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (osc_pulse),
      .rise_pulse (pulse_edge)
   );

   assign on_now    = (state == CH_ON);
   assign count_en  = pulse_edge & on_now & cmd_on & ~overtemp;
   assign acc_clear = ~(on_now & cmd_on);

   fts_energy_accum #(.TRIP_COUNT(TRIP_COUNT)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (acc_clear),
      .count_en (count_en),
      .reach    (reach)
   );

   assign cool_run = (state == CH_COOL) & cmd_on;

   fts_cooldown_timer #(.COOLDOWN_CYCLES(COOLDOWN_CYCLES)) u_cool (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (cool_run),
      .done  (cool_done)
   );

   assign trip = on_now & (fast_fault | reach);

   fts_retry_seq #(.MAX_RETRIES(MAX_RETRIES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_on    (cmd_on),
      .trip      (trip),
      .cool_done (cool_done),
      .state     (state)
   );

   assign gate_en = on_now & ~overtemp;
   assign status  = state;
   assign fault   = state[1] | overtemp;

   // R2: any trip with the command held leaves the on state
   p_trip_leaves_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (trip && cmd_on && $past(cmd_on)) |=> (status != 2'b01));

   // R8: a low command forces off with the gate open
   p_cmd_low_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_on |=> (status == 2'b00 && !gate_en));

endmodule

// File: tb/fuse_trip_supervisor_bench.sv
module fuse_trip_supervisor_bench;

   localparam int TC = 8;
   localparam int CD = 5;
   localparam int MR = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_on = 1'b0;
   logic       osc_pulse = 1'b0;
   logic       overtemp = 1'b0;
   logic       fast_fault = 1'b0;
   logic       gate_en;
   logic [1:0] status;
   logic       fault;

   int errors = 0;
   int checks = 0;

   // reference model state
   int m_st = 0, m_acc = 0, m_tmr = 0, m_ret = 0;
   bit m_cmdq = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0;
   bit m_ed, m_rise;

   fuse_trip_supervisor #(
      .TRIP_COUNT(TC), .COOLDOWN_CYCLES(CD), .MAX_RETRIES(MR), .SYNC_STAGES(2)
   ) u_fuse_trip_supervisor (
      .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .osc_pulse(osc_pulse),
      .overtemp(overtemp), .fast_fault(fast_fault),
      .gate_en(gate_en), .status(status), .fault(fault)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_acc = 0; m_tmr = 0; m_ret = 0;
         m_cmdq = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      end else begin
         m_ed = m_s2 && !m_s3;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = osc_pulse;
         m_rise = cmd_on && !m_cmdq;
         m_cmdq = cmd_on;
         if (!cmd_on) begin
            m_st = 0; m_acc = 0; m_tmr = 0;
         end else if (m_rise) begin
            m_st = 1; m_acc = 0; m_ret = 0; m_tmr = 0;
         end else if (m_st == 1) begin
            if (fast_fault || (m_ed && !overtemp && m_acc == TC - 1)) begin
               m_acc = 0; m_tmr = 0;
               m_st = (m_ret == MR) ? 3 : 2;
            end else if (m_ed && !overtemp) begin
               m_acc++;
            end
         end else if (m_st == 2) begin
            if (m_tmr == CD - 1) begin
               m_st = 1; m_ret++; m_acc = 0; m_tmr = 0;
            end else begin
               m_tmr++;
            end
         end
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      chk("R9 status", int'(status), m_st);
      chk("R6 gate_en", int'(gate_en), (m_st == 1 && !overtemp) ? 1 : 0);
      chk("R9 fault", int'(fault), (m_st >= 2 || overtemp) ? 1 : 0);
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         osc_pulse = 1'b1; tick(2);
         osc_pulse = 1'b0; tick(2);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R10 reset status", int'(status), 0);
      chk("R10 reset gate", int'(gate_en), 0);

      cmd_on = 1'b1; tick(2);
      chk("R5 on after command", int'(status), 1);
      chk("R5 gate closed", int'(gate_en), 1);

      pulses(7); tick(2);
      chk("R2 below limit stays on", int'(status), 1);
      pulses(1); tick(1);
      chk("R2 trip at limit", int'(status), 2);
      chk("R2 gate open after trip", int'(gate_en), 0);
      chk("R9 fault while cooling", int'(fault), 1);

      tick(6);
      chk("R3 restart after cooldown", int'(status), 1);

      pulses(6);
      osc_pulse = 1'b1; tick(20);
      osc_pulse = 1'b0; tick(4);
      chk("R1 held level counts once", int'(status), 1);
      pulses(1); tick(1);
      chk("R1 eighth edge trips", int'(status), 2);

      tick(6);
      fast_fault = 1'b1; tick(1);
      fast_fault = 1'b0; tick(1);
      chk("R7 fast fault trips", int'(status), 2);
      tick(6);
      chk("R3 third restart", int'(status), 1);

      fast_fault = 1'b1; tick(1);
      fast_fault = 1'b0; tick(2);
      chk("R4 lockout after retries", int'(status), 3);
      tick(20);
      chk("R4 lockout holds", int'(status), 3);
      chk("R4 gate open in lockout", int'(gate_en), 0);

      cmd_on = 1'b0; tick(2);
      chk("R8 off when commanded low", int'(status), 0);
      pulses(10);
      chk("R8 pulses ignored while off", int'(status), 0);
      chk("R8 gate open while off", int'(gate_en), 0);

      cmd_on = 1'b1; tick(2);
      chk("R5 re-command clears lockout", int'(status), 1);
      pulses(7); tick(2);
      chk("R8 count cleared by off", int'(status), 1);

      overtemp = 1'b1; #1;
      chk("R6 gate open on overtemp", int'(gate_en), 0);
      chk("R6 status unchanged", int'(status), 1);
      chk("R9 fault on overtemp", int'(fault), 1);
      pulses(3);
      overtemp = 1'b0; #1;
      chk("R6 gate back after clear", int'(gate_en), 1);
      tick(2);
      chk("R6 pulses not counted", int'(status), 1);
      pulses(1); tick(1);
      chk("R5 retries cleared so cooling", int'(status), 2);

      while (!(m_st == 2 && m_tmr == CD - 1)) tick(1);
      cmd_on = 1'b0; tick(1);
      chk("R8 drop beats cooldown end", int'(status), 0);

      cmd_on = 1'b1; tick(2);
      chk("R5 on again", int'(status), 1);
      overtemp = 1'b1; fast_fault = 1'b1; tick(1);
      fast_fault = 1'b0; overtemp = 1'b0; tick(1);
      chk("R7 fast fault under overtemp", int'(status), 2);

      tick(10);
      finish_run();
   end

endmodule